// File: doc/BRIEF.md
# Parallel Panel Frame Write Engine

This block streams one frame of pixels to a command-mode LCD panel over an 8080-style parallel write bus. Every pixel is one bus write. The write is built from four programmable phases: chip-select lead-in, strobe setup, strobe low, and strobe hold. Pixels arrive on a valid/ready stream. The engine drives an active-low chip select, an active-low write strobe, a register-select line and a parallel data bus.

Software programs the phase lengths, an enable bit and the frame geometry through a small word-wide register port. A frame can start in two ways. A direct software trigger starts it at once. Alternatively, software arms an update, and the next tearing-effect pulse from the panel starts the frame. While a frame is in flight, any further trigger is dropped, because a second trigger can reset the panel. When the last pixel write completes, a sticky frame-done flag is set and drives the interrupt output. The busy state clears in the same cycle. Writing a 1 to the flag clears it.

Top module: `lcd_pbus_writer`

## Requirements
- R1: After reset, chip select and write strobe are high, `pix_ready` and `irq_frame_done` are low, and the timing register (address 0) reads 0x0000_0100: every phase is 0 except the strobe-low field, which is 1, and the engine is disabled.
- R2: Timing register fields: bit 0 is the enable bit, bits 19:16 are the chip-select lead-in count, bits 15:12 are the strobe setup count, bits 11:8 are the strobe-low count and bits 7:4 are the strobe hold count.
- R3: Each pixel write holds chip select low for exactly lead-in + setup + strobe-low + hold cycles. A programmed strobe-low count of 0 acts as 1.
- R4: The write strobe is low only inside a write. It falls after exactly lead-in + setup cycles of chip select low and stays low for the effective strobe-low count.
- R5: The data bus carries the accepted pixel and stays stable for every cycle that chip select is low. The register-select line is high during writes.
- R6: A frame is width × height pixel writes. Width is in bits 11:0 and height in bits 27:16 of the geometry register (address 3). `pix_ready` is high only while a frame is in flight and between writes. A frame of 0 pixels completes with no writes.
- R7: Writing 0b11 to bits 1:0 of the trigger register (address 1) starts a frame when the engine is enabled and idle.
- R8: A trigger or arm request that arrives while a frame is in flight is ignored and starts no further frame.
- R9: At the end of a frame, status bit 0 (address 2) and `irq_frame_done` go high, and busy (status bit 1) goes low in the same cycle.
- R10: Writing 1 to status bit 0 clears the frame-done flag. Writing 0 leaves it unchanged.
- R11: Writing 0b01 to trigger bits 1:0 arms an update, which reads back as trigger bit 2. A `te_pulse` starts a frame only while an update is armed, and starting the frame consumes that update. A pulse with nothing armed does nothing.
- R12: With enable at 0, chip select and write strobe are held high and triggers are ignored. Clearing enable during a frame aborts it at once, without setting frame-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| te_pulse | input | 1 | Tearing-effect pulse from the panel |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Pixel stream ready |
| pix_data | input | 24 | Pixel stream data |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_rs | output | 1 | Register-select line, high for data writes |
| lcd_data | output | 24 | Panel data bus |
| irq_frame_done | output | 1 | Frame-done interrupt, level |

## Verification
The hardest case to reach is a trigger that lands inside a running frame. The stimulus issues a second software trigger, and later an arm request, in the cycles right after a frame has started. It then counts that exactly the expected number of writes appear and that the engine goes idle afterwards. The tearing-effect path takes a sequence of steps: a pulse with nothing armed, an arm, the starting pulse, and a second pulse after the frame completes, which must do nothing. The abort case is reached by waiting until chip select is low in the middle of a write and then clearing enable.

// File: rtl/lcd_pbus_pkg.sv
`timescale 1ns/1ps
package lcd_pbus_pkg;

    localparam int PH_W = 4;

    localparam logic [1:0] A_TIMING = 2'd0;
    localparam logic [1:0] A_TRIG   = 2'd1;
    localparam logic [1:0] A_STAT   = 2'd2;
    localparam logic [1:0] A_GEOM   = 2'd3;

    typedef enum logic [2:0] {
        XS_IDLE, XS_FETCH, XS_CSS, XS_WRS, XS_ACT, XS_HLD, XS_FIN
    } xfer_state_e;

    typedef struct packed {
        logic [PH_W-1:0] cs_lead;
        logic [PH_W-1:0] wr_setup;
        logic [PH_W-1:0] wr_low;
        logic [PH_W-1:0] wr_hold;
        logic            en;
    } bus_timing_t;

    function automatic logic [PH_W-1:0] eff_low(input bus_timing_t t);
        return (t.wr_low == '0) ? PH_W'(1) : t.wr_low;
    endfunction

    // Next non-empty phase; XS_FETCH marks the end of one write
    function automatic xfer_state_e phase_after(input xfer_state_e cur, input bus_timing_t t);
        case (cur)
            XS_FETCH: return (t.cs_lead != '0) ? XS_CSS : ((t.wr_setup != '0) ? XS_WRS : XS_ACT);
            XS_CSS:   return (t.wr_setup != '0) ? XS_WRS : XS_ACT;
            XS_WRS:   return XS_ACT;
            XS_ACT:   return (t.wr_hold != '0) ? XS_HLD : XS_FETCH;
            default:  return XS_FETCH;
        endcase
    endfunction

    function automatic logic [PH_W-1:0] phase_load(input xfer_state_e s, input bus_timing_t t);
        case (s)
            XS_CSS:  return t.cs_lead - PH_W'(1);
            XS_WRS:  return t.wr_setup - PH_W'(1);
            XS_ACT:  return eff_low(t) - PH_W'(1);
            XS_HLD:  return t.wr_hold - PH_W'(1);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/lcd_pbus_regs.sv
`timescale 1ns/1ps
module lcd_pbus_regs
    import lcd_pbus_pkg::*;
#(
    parameter int DIM_W = 12,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             busy,
    input  logic             frame_end,
    input  logic             te,
    output bus_timing_t      timing,
    output logic [DIM_W-1:0] width,
    output logic [DIM_W-1:0] height,
    output logic             start,
    output logic             done
);
    localparam int H_LSB = 16;

    logic pending;
    logic trig_wr, sw_go, arm;
    logic unused_wdata;

    assign unused_wdata = ^wdata;
    assign trig_wr = we && (addr == A_TRIG);
    assign sw_go   = trig_wr && (wdata[1:0] == 2'b11);
    assign arm     = trig_wr && (wdata[1:0] == 2'b01) && timing.en && !busy;
    assign start   = timing.en && !busy && (sw_go || (te && pending));

    always_ff @(posedge clk) begin
        if (rst) begin
            timing  <= '{cs_lead: '0, wr_setup: '0, wr_low: PH_W'(1), wr_hold: '0, en: 1'b0};
            width   <= '0;
            height  <= '0;
            pending <= 1'b0;
            done    <= 1'b0;
        end else begin
            if (we && addr == A_TIMING) begin
                timing.cs_lead  <= wdata[19:16];
                timing.wr_setup <= wdata[15:12];
                timing.wr_low   <= wdata[11:8];
                timing.wr_hold  <= wdata[7:4];
                timing.en       <= wdata[0];
            end
            if (we && addr == A_GEOM) begin
                width  <= wdata[DIM_W-1:0];
                height <= wdata[H_LSB +: DIM_W];
            end
            if (!timing.en || start)
                pending <= 1'b0;
            else if (arm)
                pending <= 1'b1;
            if (frame_end)
                done <= 1'b1;
            else if (we && addr == A_STAT && wdata[0])
                done <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_TIMING: begin
                rdata[19:16] = timing.cs_lead;
                rdata[15:12] = timing.wr_setup;
                rdata[11:8]  = timing.wr_low;
                rdata[7:4]   = timing.wr_hold;
                rdata[0]     = timing.en;
            end
            A_TRIG:  rdata[2] = pending;
            A_STAT:  rdata[1:0] = {busy, done};
            default: begin
                rdata[DIM_W-1:0]     = width;
                rdata[H_LSB +: DIM_W] = height;
            end
        endcase
    end

    // R9
    done_set_chk: assert property (@(posedge clk) disable iff (rst) frame_end |=> done);
    // R10
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_STAT && wdata[0] && !frame_end) |=> !done);
endmodule

// File: rtl/lcd_pbus_xfer.sv
`timescale 1ns/1ps
module lcd_pbus_xfer
    import lcd_pbus_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_timing_t      timing,
    input  logic             start,
    input  logic [CNT_W-1:0] total,
    input  logic             pix_valid,
    output logic             pix_ready,
    input  logic [PIX_W-1:0] pix_data,
    output logic             cs_n,
    output logic             wr_n,
    output logic             rs,
    output logic [PIX_W-1:0] data,
    output logic             busy,
    output logic             frame_end
);
    xfer_state_e      state, nxt_ph;
    logic [PH_W-1:0]  ph_cnt;
    logic [CNT_W-1:0] left;
    logic [PIX_W-1:0] data_q;
    logic             in_write;

    assign nxt_ph = phase_after(state, timing);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= XS_IDLE;
            ph_cnt <= '0;
            left   <= '0;
            data_q <= '0;
        end else if (!timing.en) begin
            state <= XS_IDLE;
        end else begin
            case (state)
                XS_IDLE: if (start) begin
                    left  <= total;
                    state <= (total == '0) ? XS_FIN : XS_FETCH;
                end
                XS_FETCH: if (pix_valid) begin
                    data_q <= pix_data;
                    left   <= left - CNT_W'(1);
                    state  <= nxt_ph;
                    ph_cnt <= phase_load(nxt_ph, timing);
                end
                XS_FIN: state <= XS_IDLE;
                default: begin
                    if (ph_cnt != '0) begin
                        ph_cnt <= ph_cnt - PH_W'(1);
                    end else if (nxt_ph == XS_FETCH) begin
                        state <= (left == '0) ? XS_FIN : XS_FETCH;
                    end else begin
                        state  <= nxt_ph;
                        ph_cnt <= phase_load(nxt_ph, timing);
                    end
                end
            endcase
        end
    end

    assign in_write  = (state == XS_CSS) || (state == XS_WRS) ||
                       (state == XS_ACT) || (state == XS_HLD);
    assign cs_n      = !(in_write && timing.en);
    assign wr_n      = !((state == XS_ACT) && timing.en);
    assign rs        = in_write && timing.en;
    assign data      = data_q;
    assign pix_ready = (state == XS_FETCH) && timing.en;
    assign busy      = (state != XS_IDLE);
    assign frame_end = (state == XS_FIN);

    // R8
    start_idle_chk: assert property (@(posedge clk) disable iff (rst) start |-> state == XS_IDLE);
    // R4
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (rst) !wr_n |-> !cs_n);
    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> $stable(data));
    // R12
    disable_idle_chk: assert property (@(posedge clk) disable iff (rst) !timing.en |=> !busy);
endmodule

// File: rtl/lcd_pbus_writer.sv
`timescale 1ns/1ps
module lcd_pbus_writer
    import lcd_pbus_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             te_pulse,
    input  logic             pix_valid,
    output logic             pix_ready,
    input  logic [PIX_W-1:0] pix_data,
    output logic             lcd_cs_n,
    output logic             lcd_wr_n,
    output logic             lcd_rs,
    output logic [PIX_W-1:0] lcd_data,
    output logic             irq_frame_done
);
    localparam int CNT_W = 2 * DIM_W;

    bus_timing_t      timing;
    logic [DIM_W-1:0] width, height;
    logic [CNT_W-1:0] total;
    logic             start, busy, frame_end;

    assign total = CNT_W'(width) * CNT_W'(height);

    lcd_pbus_regs #(.DIM_W(DIM_W), .REG_W(32)) regs_i (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy), .frame_end(frame_end), .te(te_pulse),
        .timing(timing), .width(width), .height(height), .start(start),
        .done(irq_frame_done)
    );

    lcd_pbus_xfer #(.PIX_W(PIX_W), .CNT_W(CNT_W)) xfer_i (
        .clk(clk), .rst(rst), .timing(timing), .start(start), .total(total),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .cs_n(lcd_cs_n), .wr_n(lcd_wr_n), .rs(lcd_rs), .data(lcd_data),
        .busy(busy), .frame_end(frame_end)
    );

    // R9
    irq_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_frame_done) |-> !busy);
endmodule

// File: tb/lcd_pbus_writer_tb_top.sv
`timescale 1ns/1ps
module lcd_pbus_writer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        te_pulse = 1'b0;
    logic        pix_valid = 1'b0;
    logic        pix_ready;
    logic [23:0] pix_data = '0;
    logic        lcd_cs_n, lcd_wr_n, lcd_rs, irq_frame_done;
    logic [23:0] lcd_data;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    lcd_pbus_writer dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .te_pulse(te_pulse), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .pix_data(pix_data), .lcd_cs_n(lcd_cs_n),
        .lcd_wr_n(lcd_wr_n), .lcd_rs(lcd_rs), .lcd_data(lcd_data),
        .irq_frame_done(irq_frame_done)
    );

    logic [23:0] src_q[$];
    logic [23:0] exp_q[$];
    int t_cs = 0, t_ws = 0, t_act = 1, t_hold = 0;
    int n_writes = 0;
    bit mon_off = 0;
    bit acc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_frame(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            src_q.push_back(24'(base + i * 24'h010203));
            exp_q.push_back(24'(base + i * 24'h010203));
        end
    endtask

    task automatic set_timing(input int cs, input int ws, input int act, input int hold);
        t_cs = cs; t_ws = ws; t_act = (act == 0) ? 1 : act; t_hold = hold;
        reg_write(2'd0, (cs << 16) | (ws << 12) | (act << 8) | (hold << 4) | 1);
    endtask

    task automatic wait_irq(input string req);
        int k = 0;
        while (!irq_frame_done && k < 2000) begin
            @(negedge clk);
            k++;
        end
        check(irq_frame_done == 1'b1, req, int'(irq_frame_done), 1);
    endtask

    // Driver side of the stream
    always @(posedge clk) acc <= pix_valid && pix_ready;
    always @(negedge clk) begin
        if (acc && src_q.size() > 0) void'(src_q.pop_front());
        if (src_q.size() > 0) begin
            pix_valid <= 1'b1;
            pix_data  <= src_q[0];
        end else begin
            pix_valid <= 1'b0;
        end
    end

    // Monitor / scoreboard
    int cs_cnt = 0, wr_cnt = 0, wr_off = 0;
    logic [23:0] first_d;
    bit data_bad = 0, rs_bad = 0;
    logic prev_cs = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (!lcd_cs_n) begin
                if (cs_cnt == 0) first_d = lcd_data;
                else if (lcd_data !== first_d) data_bad = 1;
                if (!lcd_rs) rs_bad = 1;
                if (!lcd_wr_n) begin
                    if (wr_cnt == 0) wr_off = cs_cnt;
                    wr_cnt++;
                end
                cs_cnt++;
            end else if (!prev_cs && !mon_off) begin
                n_writes++;
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected write", 1, 0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check(first_d == e, "R5 data", int'(first_d), int'(e));
                    check(!data_bad && !rs_bad, "R5 stable data/rs", int'(data_bad), 0);
                    check(cs_cnt == t_cs + t_ws + t_act + t_hold, "R3 cs length",
                          cs_cnt, t_cs + t_ws + t_act + t_hold);
                    check(wr_cnt == t_act, "R4 strobe length", wr_cnt, t_act);
                    check(wr_off == t_cs + t_ws, "R4 strobe offset", wr_off, t_cs + t_ws);
                end
            end
            if (lcd_cs_n) begin
                cs_cnt = 0; wr_cnt = 0; data_bad = 0; rs_bad = 0;
            end
            prev_cs = lcd_cs_n;
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int w0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(2'd0, rd);
        check(rd == 32'h100, "R1 timing reset", int'(rd), 32'h100);
        check(lcd_cs_n && lcd_wr_n && !pix_ready && !irq_frame_done, "R1 outputs idle",
              int'({lcd_cs_n, lcd_wr_n, pix_ready, irq_frame_done}), 4'b1100);

        // R2 R7 R6 R9: default phases, 2x2 frame
        set_timing(0, 0, 1, 0);
        reg_read(2'd0, rd);
        check(rd == 32'h101, "R2 timing readback", int'(rd), 32'h101);
        reg_write(2'd3, (2 << 16) | 2);
        send_frame(4, 24'h100000);
        w0 = n_writes;
        reg_write(2'd1, 3);
        wait_irq("R7 R9 frame done");
        reg_read(2'd2, rd);
        check(rd[1:0] == 2'b01, "R9 status done, not busy", int'(rd[1:0]), 1);
        check(n_writes - w0 == 4, "R6 pixel count", n_writes - w0, 4);

        // R10 W1C
        reg_write(2'd2, 0);
        check(irq_frame_done == 1'b1, "R10 write 0 keeps flag", int'(irq_frame_done), 1);
        reg_write(2'd2, 1);
        check(irq_frame_done == 1'b0, "R10 write 1 clears", int'(irq_frame_done), 0);

        // R3 R4 R8: long phases, double trigger and arm while busy
        set_timing(2, 1, 3, 2);
        reg_write(2'd3, (1 << 16) | 3);
        send_frame(3, 24'h0a0b0c);
        w0 = n_writes;
        reg_write(2'd1, 3);
        reg_read(2'd2, rd);
        check(rd[1] == 1'b1, "R8 busy during frame", int'(rd[1]), 1);
        reg_write(2'd1, 3);
        reg_write(2'd1, 1);
        reg_read(2'd1, rd);
        check(rd[2] == 1'b0, "R8 arm ignored while busy", int'(rd[2]), 0);
        wait_irq("R8 frame done");
        reg_write(2'd2, 1);
        repeat (60) @(negedge clk);
        check(n_writes - w0 == 3, "R8 no second frame", n_writes - w0, 3);
        check(!irq_frame_done && !pix_ready, "R6 idle, ready low", int'({irq_frame_done, pix_ready}), 0);

        // R3 strobe-low of 0 acts as 1
        set_timing(0, 1, 0, 1);
        reg_write(2'd3, (1 << 16) | 2);
        send_frame(2, 24'h555555);
        reg_write(2'd1, 3);
        wait_irq("R3 clamp frame done");
        reg_write(2'd2, 1);

        // R11 TE gating
        set_timing(1, 0, 2, 1);
        send_frame(2, 24'h0f0000);
        w0 = n_writes;
        @(negedge clk) te_pulse = 1'b1;
        @(negedge clk) te_pulse = 1'b0;
        repeat (5) @(negedge clk);
        reg_read(2'd2, rd);
        check(rd[1] == 1'b0, "R11 TE without arm ignored", int'(rd[1]), 0);
        reg_write(2'd1, 1);
        reg_read(2'd1, rd);
        check(rd[2] == 1'b1, "R11 armed", int'(rd[2]), 1);
        check(!pix_ready && lcd_cs_n, "R11 arm alone does not start", int'(pix_ready), 0);
        @(negedge clk) te_pulse = 1'b1;
        @(negedge clk) te_pulse = 1'b0;
        reg_read(2'd2, rd);
        check(rd[1] == 1'b1, "R11 TE starts frame", int'(rd[1]), 1);
        wait_irq("R11 frame done");
        reg_write(2'd2, 1);
        @(negedge clk) te_pulse = 1'b1;
        @(negedge clk) te_pulse = 1'b0;
        repeat (20) @(negedge clk);
        reg_read(2'd2, rd);
        check(rd[1] == 1'b0 && n_writes - w0 == 2, "R11 second TE consumed", n_writes - w0, 2);

        // R12 disabled: triggers ignored
        reg_write(2'd0, 32'h100);
        reg_write(2'd1, 3);
        repeat (5) @(negedge clk);
        reg_read(2'd2, rd);
        check(rd[1] == 1'b0 && lcd_cs_n && lcd_wr_n, "R12 trigger ignored when disabled",
              int'(rd[1]), 0);

        // R12 abort mid-frame
        set_timing(1, 1, 3, 1);
        reg_write(2'd3, (1 << 16) | 4);
        send_frame(4, 24'h330000);
        reg_write(2'd1, 3);
        while (lcd_cs_n) @(negedge clk);
        mon_off = 1;
        reg_write(2'd0, 32'h100);
        check(lcd_cs_n && lcd_wr_n, "R12 outputs released on abort", int'({lcd_cs_n, lcd_wr_n}), 3);
        src_q.delete();
        exp_q.delete();
        repeat (5) @(negedge clk);
        reg_read(2'd2, rd);
        check(rd[1:0] == 2'b00 && !irq_frame_done, "R12 abort: idle, no done", int'(rd[1:0]), 0);
        mon_off = 0;

        // R6 zero-pixel frame
        set_timing(0, 0, 1, 0);
        reg_write(2'd3, 0);
        w0 = n_writes;
        reg_write(2'd1, 3);
        wait_irq("R6 empty frame done");
        check(n_writes == w0, "R6 empty frame no writes", n_writes - w0, 0);
        check(exp_q.size() == 0, "R6 all pixels written", exp_q.size(), 0);

        finish_run();
    end
endmodule